// File: doc/BRIEF.md
# Keyed Configuration Item Reader

This block lets a host read a fixed table of configuration items, one byte stream at a time. The host first writes a 16-bit key, which picks an item. Each later data read returns the next 1 to 8 bytes of that item and moves a hidden read position forward. Item contents come from a small internal ROM whose bytes are computed from the key, so the table needs no storage.

A select is a write to the control target. A read is an access to the data target. A parameter switches the block to a combined-port form, where one target takes both: a 2-byte write selects an item and a 1-byte access moves data. An access that breaks the size or direction rules is refused. The block flags it for one cycle and does nothing else.

Responses are registered. Read data and its valid strobe, or the error strobe, appear on the clock edge that follows the accepted access.

Top module: `cfg_item_port`

## Requirements
- R1: After reset the selected key is 0x0000 and the read position is zero. Item 0 of bank 0 is the 4-byte signature `SIG`, and its most significant byte comes first in the stream.
- R2: Bit 14 of the key is the bank bit. The index is key & 0x3FFF, so bit 15 is ignored. The selection is valid only when the index is below FILE_FIRST + FILE_SLOTS, which is 0x40 by default.
- R3: Every accepted select sets the read position to zero, whether or not the new key is valid.
- R4: An accepted read of N bytes (N = acc_size) pulses rd_valid on the next edge. It places the next item bytes in the low 8*N bits of rd_data, with the earliest byte most significant and every bit above 8*N cleared. When the item ends early, the remaining low bytes are zero.
- R5: A read returns all zeros when the selection is invalid, when the item length is zero, or when the read position has reached the item length.
- R6: The read position advances by the number of item bytes delivered and stops at the item length.
- R7: Accepted writes to the data target change neither the key nor the read position, and they give no read response.
- R8: Item 1 of bank 0 is 4 bytes long. Byte 0 is {6'b0, DMA_EN, 1'b1} and the other three bytes are zero.
- R9: Every other item, in either bank, with index i and bank b has length (5*i + 3*b) mod 13. Its byte k is (29*i + 17*k + 128*b) mod 256.
- R10: In split mode (COMBINED=0), the control target (acc_ctl=1) accepts only 2-byte writes, and each one is a select. The data target accepts reads and writes of 1 to 8 bytes.
- R11: In combined mode (COMBINED=1), acc_ctl is ignored. A 1-byte read is a data read, a 1-byte write is a data write, and a 2-byte write is a select. Every other size, and any 2-byte read, is refused.
- R12: A refused access pulses access_error for one cycle on the next edge. It leaves the key and the read position unchanged and raises no rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ctl | input | 1 | 1 = control target, 0 = data target (split mode only) |
| acc_size | input | 4 | Access size in bytes |
| acc_wdata | input | 16 | Key for a select write |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | 64 | Packed read data |
| access_error | output | 1 | Refused access strobe |

## Verification
A wrong key or read position never shows until the next data read. At that read it appears at once, as bytes that are shifted or taken from the wrong item, or as zeros where data was expected. For this reason, every select and every write in the stimulus is followed by reads of several sizes, and the bench compares them with a model byte for byte on the very next response. A read position that fails to saturate is exposed by reads that run past the item end, which must keep returning zeros. A refused access that changes state anyway is exposed by the read that follows it.

// File: rtl/cfg_item_port.sv
module cfg_item_port #(
  parameter int          BANK_BIT   = 14,
  parameter int          IDX_W      = 14,
  parameter int          FILE_FIRST = 32,
  parameter int          FILE_SLOTS = 32,
  parameter bit          DMA_EN     = 1'b1,
  parameter bit          COMBINED   = 1'b0,
  parameter logic [31:0] SIG        = 32'h4346_4731
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic        acc_ctl,
  input  logic [3:0]  acc_size,
  input  logic [15:0] acc_wdata,
  output logic        rd_valid,
  output logic [63:0] rd_data,
  output logic        access_error
);
  localparam int LIMIT = FILE_FIRST + FILE_SLOTS;

  logic [15:0] key_q;
  logic [31:0] off_q;

  wire [IDX_W-1:0] idx  = key_q[IDX_W-1:0];
  wire             bank = key_q[BANK_BIT];
  wire             sel_ok = 32'(idx) < LIMIT;

  function automatic logic [31:0] item_len(input logic b, input logic [IDX_W-1:0] i);
    if (!b && (i == 0 || i == 1)) return 32'd4;
    return (32'(i) * 32'd5 + (b ? 32'd3 : 32'd0)) % 32'd13;
  endfunction

  function automatic logic [7:0] item_byte(input logic b, input logic [IDX_W-1:0] i,
                                           input logic [31:0] k);
    if (!b && i == 0) return SIG[8*(3-k[1:0]) +: 8];
    if (!b && i == 1) return (k == 0) ? {6'b0, DMA_EN, 1'b1} : 8'h00;
    return 8'(32'(i) * 32'd29 + k * 32'd17 + (b ? 32'd128 : 32'd0));
  endfunction

  logic legal, is_sel, is_rd;
  wire  sz_ok = (acc_size >= 4'd1) && (acc_size <= 4'd8);

  generate
    if (COMBINED) begin : g_comb
      assign legal  = (acc_size == 4'd1) || (acc_write && acc_size == 4'd2);
      assign is_sel = acc_write && acc_size == 4'd2;
      assign is_rd  = !acc_write && acc_size == 4'd1;
    end else begin : g_split
      assign legal  = acc_ctl ? (acc_write && acc_size == 4'd2) : sz_ok;
      assign is_sel = acc_ctl && acc_write && acc_size == 4'd2;
      assign is_rd  = !acc_ctl && !acc_write && sz_ok;
    end
  endgenerate

  wire [31:0] cur_len = sel_ok ? item_len(bank, idx) : 32'd0;
  wire [31:0] avail   = (off_q < cur_len) ? cur_len - off_q : 32'd0;
  wire [31:0] sz32    = {28'd0, acc_size};
  wire [31:0] take    = (sz32 < avail) ? sz32 : avail;

  logic [63:0] rdat;
  always_comb begin
    rdat = '0;
    for (int j = 0; j < 8; j++) begin
      if (32'(j) < take)
        rdat[8*(int'(acc_size)-1-j) +: 8] = item_byte(bank, idx, off_q + 32'(j));
    end
  end

  wire acc_ok = acc_valid && legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_q        <= 16'h0000;
      off_q        <= '0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      access_error <= 1'b0;
    end else begin
      rd_valid     <= acc_ok && is_rd;
      access_error <= acc_valid && !legal;
      if (acc_ok && is_sel) begin
        key_q <= acc_wdata;
        off_q <= '0;
      end else if (acc_ok && is_rd) begin
        off_q   <= off_q + take;
        rd_data <= rdat;
      end
    end
  end

  a_r3_select_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && is_sel) |=> (off_q == 32'd0));

  a_r6_offset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    sel_ok |-> (off_q <= cur_len));

  a_r12_refused_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !legal) |=> (access_error && !rd_valid && $stable(key_q) && $stable(off_q)));

  a_r7_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && acc_write && !is_sel) |=> ($stable(key_q) && $stable(off_q) && !rd_valid));

  a_r5_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && is_rd && !sel_ok) |=> (rd_data == 64'd0));

  a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && is_rd) |=> ((rd_data >> (32'd8 * 32'($past(acc_size)))) == 64'd0));

  a_r12_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && access_error));
endmodule

// File: tb/cfg_item_port_bench.sv
`timescale 1ns/1ps
module cfg_item_port_bench;
  localparam logic [31:0] SIG = 32'h4346_4731;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;
  logic rst_n = 1'b0;

  logic v0 = 0, w0 = 0, c0 = 0; logic [3:0] s0 = 0; logic [15:0] d0 = 0;
  logic v1 = 0, w1 = 0, c1 = 0; logic [3:0] s1 = 0; logic [15:0] d1 = 0;
  logic rv0, er0, rv1, er1; logic [63:0] rd0, rd1;

  cfg_item_port #(.DMA_EN(1'b1), .COMBINED(1'b0), .SIG(SIG)) u_cfg_item_port (
    .clk(clk), .rst_n(rst_n), .acc_valid(v0), .acc_write(w0), .acc_ctl(c0),
    .acc_size(s0), .acc_wdata(d0), .rd_valid(rv0), .rd_data(rd0), .access_error(er0));

  cfg_item_port #(.DMA_EN(1'b0), .COMBINED(1'b1), .SIG(SIG)) u_cfg_item_port_comb (
    .clk(clk), .rst_n(rst_n), .acc_valid(v1), .acc_write(w1), .acc_ctl(c1),
    .acc_size(s1), .acc_wdata(d1), .rd_valid(rv1), .rd_data(rd1), .access_error(er1));

  int checks = 0, errors = 0;
  logic [15:0] mkey [2];
  longint      moff [2];

  function automatic longint m_len(logic [15:0] key);
    int i = int'(key & 16'h3FFF);
    int b = int'(key[14]);
    if (i >= 64) return 0;
    if (b == 0 && (i == 0 || i == 1)) return 4;
    return (5 * i + 3 * b) % 13;
  endfunction

  function automatic logic [7:0] m_byte(logic [15:0] key, longint k, bit dma);
    int i = int'(key & 16'h3FFF);
    int b = int'(key[14]);
    if (b == 0 && i == 0) return SIG[8*(3-k) +: 8];
    if (b == 0 && i == 1) return (k == 0) ? {6'b0, dma, 1'b1} : 8'h00;
    return 8'((29 * i + 17 * k + 128 * b) % 256);
  endfunction

  function automatic bit m_legal(int inst, bit wr, bit ctl, int sz);
    if (inst == 1) return (sz == 1) || (wr && sz == 2);
    if (ctl) return wr && sz == 2;
    return sz >= 1 && sz <= 8;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic acc(int inst, bit wr, bit ctl, int sz, logic [15:0] wd, string tag);
    bit lg = m_legal(inst, wr, ctl, sz);
    bit sel = lg && wr && ((inst == 1) ? sz == 2 : ctl);
    bit rd = lg && !wr && ((inst == 1) ? 1'b1 : !ctl);
    logic [63:0] ev = '0;
    longint len = m_len(mkey[inst]);
    longint avail = (moff[inst] < len) ? len - moff[inst] : 0;
    longint tk = (sz < avail) ? sz : avail;
    logic grv, ger; logic [63:0] grd;
    for (int j = 0; j < tk; j++)
      ev[8*(sz-1-j) +: 8] = m_byte(mkey[inst], moff[inst] + j, inst == 0);
    @(negedge clk);
    if (inst == 0) begin v0 = 1; w0 = wr; c0 = ctl; s0 = 4'(sz); d0 = wd; end
    else begin v1 = 1; w1 = wr; c1 = ctl; s1 = 4'(sz); d1 = wd; end
    @(negedge clk);
    v0 = 0; v1 = 0;
    grv = (inst == 0) ? rv0 : rv1;
    ger = (inst == 0) ? er0 : er1;
    grd = (inst == 0) ? rd0 : rd1;
    if (rd) check(grv && !ger && grd == ev, tag, grd, ev);
    else    check(grv == 1'b0 && ger == !lg, tag, {62'd0, grv, ger}, {63'd0, !lg});
    if (sel) begin mkey[inst] = wd; moff[inst] = 0; end
    else if (rd) moff[inst] += tk;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 2; i++) begin mkey[i] = 16'h0000; moff[i] = 0; end
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    do_reset();
    @(negedge clk);
    check(!rv0 && !er0 && !rv1 && !er1 && rd0 == 0, "R1 reset outputs", {60'd0, rv0, er0, rv1, er1}, 64'd0);
    acc(0, 0, 0, 4, 0, "R1 signature read");
    acc(0, 0, 0, 1, 0, "R5 past end");
    acc(0, 1, 1, 2, 16'h0001, "R10 select version");
    acc(0, 0, 0, 8, 0, "R8 R4 version padded");
    acc(0, 1, 1, 2, 16'h0002, "R10 select item 2");
    acc(0, 0, 0, 3, 0, "R9 R4 read 3");
    acc(0, 0, 0, 3, 0, "R6 advance");
    acc(0, 1, 0, 4, 16'hFFFF, "R7 data write");
    acc(0, 0, 0, 8, 0, "R6 R4 run out");
    acc(0, 0, 0, 2, 0, "R6 saturated");
    acc(0, 1, 1, 2, 16'h0002, "R3 reselect");
    acc(0, 0, 0, 2, 0, "R3 restart");
    acc(0, 1, 1, 2, 16'h0040, "R2 select invalid");
    acc(0, 0, 0, 8, 0, "R5 invalid zero");
    acc(0, 1, 1, 2, 16'h003F, "R2 last valid");
    acc(0, 0, 0, 8, 0, "R2 last item read");
    acc(0, 1, 1, 2, 16'h4000, "R2 bank select");
    acc(0, 0, 0, 4, 0, "R9 bank item");
    acc(0, 1, 1, 2, 16'h8005, "R2 bit15 masked");
    acc(0, 0, 0, 5, 0, "R2 masked read");
    acc(0, 1, 1, 2, 16'h000D, "R5 empty select");
    acc(0, 0, 0, 4, 0, "R5 empty read");
    acc(0, 0, 1, 2, 0, "R12 ctl read");
    acc(0, 1, 1, 1, 16'h0001, "R12 ctl byte write");
    acc(0, 0, 0, 0, 0, "R12 size 0");
    acc(0, 0, 0, 9, 0, "R12 size 9");
    acc(0, 0, 0, 1, 0, "R12 state kept");
    acc(1, 0, 1, 1, 0, "R11 R1 comb sig byte");
    acc(1, 1, 0, 2, 16'h0001, "R11 comb select");
    acc(1, 0, 0, 1, 0, "R8 no dma");
    acc(1, 0, 0, 4, 0, "R11 comb size 4");
    acc(1, 0, 0, 2, 0, "R11 comb read 2");
    acc(1, 1, 1, 1, 16'h0000, "R7 comb byte write");
    acc(1, 0, 0, 1, 0, "R7 comb after write");
    do_reset();
    acc(0, 0, 0, 4, 0, "R1 after reset");
    acc(1, 0, 0, 1, 0, "R1 comb after reset");
    for (int n = 0; n < 3000; n++) begin
      int inst = int'($urandom % 2);
      int op = int'($urandom % 10);
      if (op < 3) begin
        logic [15:0] k = {1'($urandom), 1'($urandom), 7'(($urandom % 8 == 0) ? $urandom : 0),
                          7'($urandom % 72)};
        acc(inst, 1, 1, 2, k, "R2 R3 random select");
      end else if (op < 8) begin
        acc(inst, 0, 0, (inst == 1) ? 1 : int'($urandom % 8) + 1, 0, "R4 R6 R9 random read");
      end else if (op < 9) begin
        acc(inst, 1, 0, (inst == 1) ? 1 : int'($urandom % 8) + 1, 16'($urandom), "R7 random write");
      end else begin
        acc(inst, 1'($urandom), 1'($urandom), int'($urandom % 16), 16'($urandom), "R10 R11 R12 random access");
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule